// File: doc/BRIEF.md
# Pushbutton Gesture Decoder

This block turns one debounced pushbutton level into board-level action strobes. It recognises two kinds of gesture. A run of quick press-and-release cycles is counted, and the count selects an action once the run has finished. A press that is held is timed, and crossing a time threshold selects an action. The actions are a hard reset, a pushbutton interrupt, a long-hold interrupt, a secure-key erase, a reset from the alternate boot device, a factory-default reload, a soft power-down and a soft wake. A separate interrupt event marks every change of the button level.

The block times everything from a 1 ms tick. Seconds are built from `MS_PER_SEC` ticks, so the bench can run a scaled-down time base. Enables come from a control vector. An 8-bit soft-power time value gives the hold thresholds for sleep and wake: the low nibble sets the sleep time and the high nibble sets the wake time, both in seconds. A sleep flag from the power logic switches the block into a mode where only the wake timing runs.

Top module: `pb_gesture_decoder`

Control-vector bit positions:

| Bit | Name | Effect |
|-----|------|--------|
| 0 | single-reset | A one-press run gives a hard reset. When this bit is clear, a one-press run gives a pushbutton interrupt. |
| 1 | erase | Enables the three-press secure-key erase. |
| 2 | soft power | Enables hold-to-sleep. |
| 3 | alt boot | Enables the five-press alternate-boot reset. |
| 4 | ten-press disable | When set, blocks the ten-press factory reload. |
| 5 | hold interrupt | Enables the long-hold interrupt. |
| 6 | change interrupt | Enables the state-change event. |

## Requirements
- R1: While reset is applied, and in the first cycle after it, every output strobe is 0.
- R2: A run of exactly one quick press behaves as follows. When control bit 0 is set, it gives a one-cycle `hard_reset_o`. When bit 0 is clear, it gives a one-cycle `pb_irq_o`. In both cases the strobe comes after the run has resolved.
- R3: A press is quick if it is released before `QUICK_MS` ticks of holding. A run continues while each release-to-press gap is shorter than `QUICK_MS` ticks. The run resolves once `QUICK_MS` ticks pass after the last release with no new press, so two presses with a longer gap form two runs.
- R4: A run of exactly three quick presses gives `key_erase_o` when control bit 1 is set.
- R5: A run of exactly five quick presses gives `alt_boot_o` when control bit 3 is set.
- R6: A run of exactly ten quick presses gives `factory_load_o` unless control bit 4 is set.
- R7: A run whose count matches no enabled gesture produces no count strobe. The counts this covers are 2, 4, 6 to 9, 11 and more, and also a disabled 3 or 5. A ten-press run with bit 4 set is also discarded.
- R8: When a hold reaches `QUICK_MS` ticks, the block gives `hold_irq_o` if control bit 5 is set. That press also ends the current run without adding to it, so no count strobe comes from presses made before it.
- R9: With control bit 2 set, `sleep_o` pulses once when a hold reaches S seconds. S is the low nibble of `spwr_time_i`, and a value of 0 counts as 1. A shorter hold gives no `sleep_o`.
- R10: While `asleep_i` is 1, `wake_o` pulses once per press. If the high nibble of `spwr_time_i` is 0, the pulse comes on the press itself. Otherwise it comes when the hold reaches that many seconds, and a shorter hold gives no `wake_o`.
- R11: While `asleep_i` is 1, every strobe other than `wake_o` stays 0, and no quick-press run is counted.
- R12: With control bit 6 set and the block awake, each change of `btn_i` gives `change_o` for exactly one cycle, in the cycle after the edge that sees the change.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| btn_i | input | 1 | Debounced button level, 1 = pressed |
| tick_ms_i | input | 1 | One-cycle 1 ms time-base pulse |
| ctrl_en_i | input | 7 | Gesture enables, bit map above |
| asleep_i | input | 1 | Board is in soft sleep |
| spwr_time_i | input | 8 | [3:0] sleep hold seconds, [7:4] wake hold seconds |
| hard_reset_o | output | 1 | Hard reset strobe |
| pb_irq_o | output | 1 | Single-press interrupt strobe |
| hold_irq_o | output | 1 | Long-hold interrupt strobe |
| key_erase_o | output | 1 | Secure-key erase strobe |
| alt_boot_o | output | 1 | Alternate-boot reset strobe |
| factory_load_o | output | 1 | Factory-default reload strobe |
| sleep_o | output | 1 | Soft power-down strobe |
| wake_o | output | 1 | Soft wake strobe |
| change_o | output | 1 | Button state-change event |

## Verification
The state-change event is due one clock after the edge that first sees the new level. The bench checks it at exactly that cycle and at the cycle after, where it must be 0. Hold strobes come one clock after the tick on which the hold counter reaches its threshold. Count strobes come one clock after the `QUICK_MS`-th tick of the post-release gap. Because the bench ticks every other clock, these strobes can only be fixed to a window of a few cycles. For hold and count gestures, the bench therefore counts every strobe pulse on the falling edge. After each gesture it waits well past the resolve window, then compares the change in each pulse count against the value it computes from the press count and the enables. One single-press run is also checked for landing inside its computed cycle window.

// File: rtl/pbg_pkg.sv
package pbg_pkg;
  localparam int EN_W          = 7;
  localparam int EN_SINGLE_RST = 0;
  localparam int EN_ERASE      = 1;
  localparam int EN_SOFT_PWR   = 2;
  localparam int EN_ALT_BOOT   = 3;
  localparam int EN_NO_FACTORY = 4;
  localparam int EN_HOLD_IRQ   = 5;
  localparam int EN_CHANGE_IRQ = 6;

  localparam int RUN_W         = 4;
  localparam int RUN_SINGLE    = 1;
  localparam int RUN_ERASE     = 3;
  localparam int RUN_ALT       = 5;
  localparam int RUN_FACTORY   = 10;

  typedef struct packed {
    logic long_hit;
    logic sleep_hit;
    logic wake_hit;
  } hold_evt_t;
endpackage

// File: rtl/pbg_hold_timer.sv
module pbg_hold_timer #(
  parameter int QUICK_MS   = 700,
  parameter int MS_PER_SEC = 1000,
  localparam int HOLD_MAX  = 16 * MS_PER_SEC,
  localparam int HW        = $clog2(HOLD_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               held,
  input  logic               btn_q,
  input  logic               tick,
  input  logic [3:0]         sleep_sec,
  input  logic [3:0]         wake_sec,
  output logic [HW-1:0]      hold_ms,
  output pbg_pkg::hold_evt_t evt
);
  logic          inc;
  logic [HW-1:0] nxt;
  logic [3:0]    sleep_eff;
  logic [HW-1:0] sleep_thr;
  logic [HW-1:0] wake_thr;

  always_comb begin
    inc       = tick && held && (hold_ms != HW'(HOLD_MAX));
    nxt       = hold_ms + HW'(1);
    sleep_eff = (sleep_sec == 4'd0) ? 4'd1 : sleep_sec;
    sleep_thr = HW'(sleep_eff) * HW'(MS_PER_SEC);
    wake_thr  = HW'(wake_sec) * HW'(MS_PER_SEC);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_ms <= '0;
      evt     <= '0;
    end else begin
      if (!btn_q)   hold_ms <= '0;
      else if (inc) hold_ms <= nxt;
      evt.long_hit  <= inc && (nxt == HW'(QUICK_MS));
      evt.sleep_hit <= inc && (nxt == sleep_thr);
      evt.wake_hit  <= inc && (wake_sec != 4'd0) && (nxt == wake_thr);
    end
  end
endmodule

// File: rtl/pbg_run_counter.sv
module pbg_run_counter #(
  parameter int QUICK_MS = 700,
  parameter int CW       = pbg_pkg::RUN_W,
  localparam int GW      = $clog2(QUICK_MS + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          btn_q,
  input  logic          rel_quick,
  input  logic          long_hit,
  input  logic          tick,
  input  logic          asleep,
  output logic          done,
  output logic [CW-1:0] runs
);
  logic [CW-1:0] cnt;
  logic [GW-1:0] gap;
  logic          open;
  logic [GW-1:0] gap_nxt;

  assign gap_nxt = gap + GW'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= '0;
      gap  <= '0;
      open <= 1'b0;
      done <= 1'b0;
      runs <= '0;
    end else begin
      done <= 1'b0;
      if (asleep || long_hit) begin
        cnt  <= '0;
        gap  <= '0;
        open <= 1'b0;
      end else if (rel_quick) begin
        if (cnt != '1) cnt <= cnt + CW'(1);
        gap  <= '0;
        open <= 1'b1;
      end else if (open && !btn_q && tick) begin
        if (gap_nxt == GW'(QUICK_MS)) begin
          done <= 1'b1;
          runs <= cnt;
          cnt  <= '0;
          gap  <= '0;
          open <= 1'b0;
        end else begin
          gap <= gap_nxt;
        end
      end
    end
  end
endmodule

// File: rtl/pb_gesture_decoder.sv
module pb_gesture_decoder #(
  parameter int QUICK_MS   = 700,
  parameter int MS_PER_SEC = 1000,
  localparam int EW        = pbg_pkg::EN_W,
  localparam int CW        = pbg_pkg::RUN_W,
  localparam int HW        = $clog2(16 * MS_PER_SEC + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          btn_i,
  input  logic          tick_ms_i,
  input  logic [EW-1:0] ctrl_en_i,
  input  logic          asleep_i,
  input  logic [7:0]    spwr_time_i,
  output logic          hard_reset_o,
  output logic          pb_irq_o,
  output logic          hold_irq_o,
  output logic          key_erase_o,
  output logic          alt_boot_o,
  output logic          factory_load_o,
  output logic          sleep_o,
  output logic          wake_o,
  output logic          change_o
);
  import pbg_pkg::*;

  logic               btn_q;
  logic               held;
  logic               press_edge;
  logic               rel_quick;
  logic [HW-1:0]      hold_ms;
  hold_evt_t          evt;
  logic               done;
  logic [CW-1:0]      runs;
  logic               awake;
  logic               r_single;
  logic               r_erase;
  logic               r_alt;
  logic               r_factory;

  always_ff @(posedge clk) begin
    if (rst) btn_q <= 1'b0;
    else     btn_q <= btn_i;
  end

  always_comb begin
    held       = btn_i && btn_q;
    press_edge = btn_i && !btn_q;
    rel_quick  = !btn_i && btn_q && (hold_ms < HW'(QUICK_MS));
    awake      = !asleep_i;
    r_single   = done && (runs == CW'(RUN_SINGLE));
    r_erase    = done && (runs == CW'(RUN_ERASE));
    r_alt      = done && (runs == CW'(RUN_ALT));
    r_factory  = done && (runs == CW'(RUN_FACTORY));
  end

  pbg_hold_timer #(
    .QUICK_MS  (QUICK_MS),
    .MS_PER_SEC(MS_PER_SEC)
  ) u_hold (
    .clk      (clk),
    .rst      (rst),
    .held     (held),
    .btn_q    (btn_q),
    .tick     (tick_ms_i),
    .sleep_sec(spwr_time_i[3:0]),
    .wake_sec (spwr_time_i[7:4]),
    .hold_ms  (hold_ms),
    .evt      (evt)
  );

  pbg_run_counter #(
    .QUICK_MS(QUICK_MS),
    .CW      (CW)
  ) u_runs (
    .clk      (clk),
    .rst      (rst),
    .btn_q    (btn_q),
    .rel_quick(rel_quick),
    .long_hit (evt.long_hit),
    .tick     (tick_ms_i),
    .asleep   (asleep_i),
    .done     (done),
    .runs     (runs)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      hard_reset_o   <= 1'b0;
      pb_irq_o       <= 1'b0;
      hold_irq_o     <= 1'b0;
      key_erase_o    <= 1'b0;
      alt_boot_o     <= 1'b0;
      factory_load_o <= 1'b0;
      sleep_o        <= 1'b0;
      wake_o         <= 1'b0;
      change_o       <= 1'b0;
    end else begin
      hard_reset_o   <= awake && r_single && ctrl_en_i[EN_SINGLE_RST];
      pb_irq_o       <= awake && r_single && !ctrl_en_i[EN_SINGLE_RST];
      key_erase_o    <= awake && r_erase && ctrl_en_i[EN_ERASE];
      alt_boot_o     <= awake && r_alt && ctrl_en_i[EN_ALT_BOOT];
      factory_load_o <= awake && r_factory && !ctrl_en_i[EN_NO_FACTORY];
      hold_irq_o     <= awake && evt.long_hit && ctrl_en_i[EN_HOLD_IRQ];
      sleep_o        <= awake && evt.sleep_hit && ctrl_en_i[EN_SOFT_PWR];
      wake_o         <= asleep_i && ((spwr_time_i[7:4] == 4'd0) ? press_edge
                                                                 : evt.wake_hit);
      change_o       <= awake && ctrl_en_i[EN_CHANGE_IRQ] && (btn_i != btn_q);
    end
  end
endmodule

// File: rtl/pbg_checker.sv
module pbg_checker (
  input logic clk,
  input logic rst,
  input logic btn_i,
  input logic asleep_i,
  input logic hard_reset_o,
  input logic pb_irq_o,
  input logic hold_irq_o,
  input logic key_erase_o,
  input logic alt_boot_o,
  input logic factory_load_o,
  input logic sleep_o,
  input logic wake_o,
  input logic change_o
);
  logic any_out;
  assign any_out = hard_reset_o | pb_irq_o | hold_irq_o | key_erase_o | alt_boot_o |
                   factory_load_o | sleep_o | wake_o | change_o;

  // R1: nothing fires right after reset
  a_r1_quiet_after_reset: assert property (@(posedge clk)
    $past(rst) |-> !any_out);

  // R2: at most one count strobe per resolved run
  a_r2_one_count_action: assert property (@(posedge clk) disable iff (rst)
    $onehot0({hard_reset_o, pb_irq_o, key_erase_o, alt_boot_o, factory_load_o}));

  // R9: power-down comes only from a held button
  a_r9_sleep_needs_hold: assert property (@(posedge clk) disable iff (rst)
    sleep_o |-> $past(btn_i, 2));

  // R8: long-hold interrupt only while held
  a_r8_hold_needs_press: assert property (@(posedge clk) disable iff (rst)
    hold_irq_o |-> $past(btn_i, 2));

  // R10: wake only while asleep
  a_r10_wake_only_asleep: assert property (@(posedge clk) disable iff (rst)
    wake_o |-> $past(asleep_i));

  // R11: asleep suppresses the other strobes
  a_r11_asleep_quiet: assert property (@(posedge clk) disable iff (rst)
    $past(asleep_i) |-> !(hard_reset_o | pb_irq_o | hold_irq_o | key_erase_o |
                          alt_boot_o | factory_load_o | sleep_o | change_o));

  // R12: change event follows a level change and lasts one cycle
  a_r12_change_from_edge: assert property (@(posedge clk) disable iff (rst)
    change_o |-> ($past(btn_i) != $past(btn_i, 2)));
endmodule

bind pb_gesture_decoder pbg_checker u_chk (
  .clk           (clk),
  .rst           (rst),
  .btn_i         (btn_i),
  .asleep_i      (asleep_i),
  .hard_reset_o  (hard_reset_o),
  .pb_irq_o      (pb_irq_o),
  .hold_irq_o    (hold_irq_o),
  .key_erase_o   (key_erase_o),
  .alt_boot_o    (alt_boot_o),
  .factory_load_o(factory_load_o),
  .sleep_o       (sleep_o),
  .wake_o        (wake_o),
  .change_o      (change_o)
);

// File: tb/sim_pb_gesture_decoder.sv
module sim_pb_gesture_decoder;
  localparam int CLK_PERIOD = 10;
  localparam int QMS = 7;
  localparam int MSS = 10;

  logic clk = 0, rst = 1, btn = 0, tick = 0, asleep = 0;
  logic [6:0] en = '0;
  logic [7:0] spwr = 8'h01;
  logic hr, pbi, hirq, ker, alt, fac, slp, wak, chg;

  int checks = 0, errors = 0;
  int n_hr = 0, n_pb = 0, n_hold = 0, n_ker = 0, n_alt = 0, n_fac = 0;
  int n_slp = 0, n_wak = 0, n_chg = 0;
  int b_hr, b_pb, b_hold, b_ker, b_alt, b_fac, b_slp, b_wak, b_chg;

  always #(CLK_PERIOD/2) clk = ~clk;

  pb_gesture_decoder #(.QUICK_MS(QMS), .MS_PER_SEC(MSS)) u0 (
    .clk(clk), .rst(rst), .btn_i(btn), .tick_ms_i(tick), .ctrl_en_i(en),
    .asleep_i(asleep), .spwr_time_i(spwr), .hard_reset_o(hr), .pb_irq_o(pbi),
    .hold_irq_o(hirq), .key_erase_o(ker), .alt_boot_o(alt), .factory_load_o(fac),
    .sleep_o(slp), .wake_o(wak), .change_o(chg));

  always @(negedge clk) begin
    tick <= rst ? 1'b0 : ~tick;
    if (!rst) begin
      n_hr += int'(hr); n_pb += int'(pbi); n_hold += int'(hirq);
      n_ker += int'(ker); n_alt += int'(alt); n_fac += int'(fac);
      n_slp += int'(slp); n_wak += int'(wak); n_chg += int'(chg);
    end
  end

  task automatic chk(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic snap();
    b_hr = n_hr; b_pb = n_pb; b_hold = n_hold; b_ker = n_ker; b_alt = n_alt;
    b_fac = n_fac; b_slp = n_slp; b_wak = n_wak; b_chg = n_chg;
  endtask

  task automatic wait_ms(input int ms);
    repeat (2 * ms) @(negedge clk);
  endtask

  task automatic press(input int hold_ms, input int gap_ms);
    btn = 1'b1; wait_ms(hold_ms);
    btn = 1'b0; wait_ms(gap_ms);
  endtask

  task automatic deltas(input string req, input int e_hr, input int e_pb, input int e_hold,
                        input int e_ker, input int e_alt, input int e_fac,
                        input int e_slp, input int e_wak);
    chk(req, "hard_reset", n_hr - b_hr, e_hr);
    chk(req, "pb_irq", n_pb - b_pb, e_pb);
    chk(req, "hold_irq", n_hold - b_hold, e_hold);
    chk(req, "key_erase", n_ker - b_ker, e_ker);
    chk(req, "alt_boot", n_alt - b_alt, e_alt);
    chk(req, "factory", n_fac - b_fac, e_fac);
    chk(req, "sleep", n_slp - b_slp, e_slp);
    chk(req, "wake", n_wak - b_wak, e_wak);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    // R1: reset state
    chk("R1", "outputs in reset", int'({hr, pbi, hirq, ker, alt, fac, slp, wak, chg}), 0);
    rst = 1'b0;
    @(negedge clk);
    chk("R1", "outputs after reset", int'({hr, pbi, hirq, ker, alt, fac, slp, wak, chg}), 0);

    // R12: exact change-event timing
    en = 7'b1000000;
    btn = 1'b1; @(negedge clk);
    chk("R12", "change next cycle", int'(chg), 1);
    @(negedge clk);
    chk("R12", "change one cycle only", int'(chg), 0);
    btn = 1'b0; @(negedge clk);
    chk("R12", "change on release", int'(chg), 1);
    wait_ms(2 * QMS);

    // R2: single-press strobe lands within its computed window
    en = 7'b0000001;
    begin
      int lat;
      bit seen;
      lat = 0; seen = 0;
      btn = 1'b1; wait_ms(3); btn = 1'b0;
      for (int c = 1; c <= 4 * QMS; c++) begin
        @(negedge clk);
        if (hr && !seen) begin lat = c; seen = 1; end
      end
      checks++;
      if (lat < 2 * QMS || lat > 2 * QMS + 3) begin
        errors++;
        $display("FAIL R2 latency actual=%0d expected=%0d..%0d", lat, 2 * QMS, 2 * QMS + 3);
      end
    end

    // R2 R4 R5 R6 R7 R12: sweep of run length under two enable sets
    for (int n = 1; n <= 11; n++) begin
      for (int k = 0; k < 2; k++) begin
        en = k ? 7'b1011011 : 7'b0000000;
        snap();
        for (int p = 0; p < n; p++) press(3, 3);
        wait_ms(2 * QMS);
        deltas(n == 1 ? "R2" : (n == 3 ? "R4" : (n == 5 ? "R5" : (n == 10 ? "R6" : "R7"))),
               (n == 1 && k == 1) ? 1 : 0, (n == 1 && k == 0) ? 1 : 0, 0,
               (n == 3 && k == 1) ? 1 : 0, (n == 5 && k == 1) ? 1 : 0,
               (n == 10 && k == 0) ? 1 : 0, 0, 0);
        chk("R12", "change count", n_chg - b_chg, k ? 2 * n : 0);
      end
    end

    // R3: long gap splits runs
    en = 7'b0000001; snap();
    press(3, 2 * QMS); press(3, 2 * QMS);
    deltas("R3", 2, 0, 0, 0, 0, 0, 0, 0);

    // R8: long hold interrupts and ends the run
    en = 7'b0100011; snap();
    press(3, 3); press(QMS + 2, 2 * QMS);
    deltas("R8", 0, 0, 1, 0, 0, 0, 0, 0);
    snap();
    press(3, 3); press(3, 3); press(3, 2 * QMS);
    deltas("R8", 0, 0, 0, 1, 0, 0, 0, 0);

    // R9: soft power-down thresholds
    en = 7'b0000100; spwr = 8'h02; snap();
    press(25, 3 * QMS);
    deltas("R9", 0, 0, 0, 0, 0, 0, 1, 0);
    snap();
    press(15, 3 * QMS);
    deltas("R9", 0, 0, 0, 0, 0, 0, 0, 0);
    spwr = 8'h00; snap();
    press(12, 3 * QMS);
    deltas("R9", 0, 0, 0, 0, 0, 0, 1, 0);

    // R10 R11: wake behaviour while asleep
    en = 7'b1111111; asleep = 1'b1; spwr = 8'h01; snap();
    press(3, 3 * QMS);
    deltas("R10", 0, 0, 0, 0, 0, 0, 0, 1);
    chk("R11", "no change while asleep", n_chg - b_chg, 0);
    spwr = 8'h32; snap();
    press(20, 3 * QMS);
    deltas("R10", 0, 0, 0, 0, 0, 0, 0, 0);
    snap();
    press(35, 3 * QMS);
    deltas("R11", 0, 0, 0, 0, 0, 0, 0, 1);
    snap();
    press(3, 3); press(3, 3); press(3, 3 * QMS);
    deltas("R11", 0, 0, 0, 0, 0, 0, 0, 0);
    asleep = 1'b0;

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule